// File: doc/BRIEF.md
# DDR2 Burst Column Address Sequencer

This block turns one burst request into the column address for every beat of a memory read or write burst. A request carries a starting column address, a burst length code, an ordering bit and a direction bit. From the clock edge that accepts it, the block presents one column address per cycle, with a valid flag and a flag that marks the final beat. The upper column bits pass through unchanged. The low three bits follow either the sequential (wrapping) order or the interleaved (XOR) order.

A new request may follow the previous burst with no idle cycle between them. A request may also cut an eight-beat burst short, but only at the end of its first four beats and only when its direction matches the running burst. A request that arrives anywhere else is parked in a one-entry holding slot and starts at the next point where it is allowed. There is no stop command. A running burst always ends at its full length or at an allowed interruption.

Top module: `ddr_burst_colseq`

## Requirements
- R1: After reset, and whenever no burst is running, `beat_valid_o` is 0 and `beat_last_o` is 0.
- R2: A length code of 3'd2 gives a 4-beat burst and 3'd3 gives an 8-beat burst. A strobe with any other length code is ignored: no burst starts and nothing is held.
- R3: `order_i` = 0 selects sequential ordering and `order_i` = 1 selects interleaved ordering. Both are latched per burst.
- R4: For a 4-beat sequential burst, column bits [1:0] count up modulo 4 from the start value, and bit 2 keeps its start value. For example, a start of 2 gives 2, 3, 0, 1.
- R5: For an 8-beat sequential burst, beats 0-3 wrap bits [1:0] modulo 4 with bit 2 held. Beats 4-7 repeat the same low pattern with bit 2 inverted. For example, a start of 5 gives 5, 6, 7, 4, 1, 2, 3, 0.
- R6: In an interleaved burst, the low bits equal the start bits XOR the beat index, over 2 bits for length 4 and 3 bits for length 8. For example, a start of 5 at length 8 gives 5, 4, 7, 6, 1, 0, 3, 2.
- R7: Column bits above bit 2 equal the start value on every beat of the burst.
- R8: `beat_last_o` is 1 on beat 3 of a 4-beat burst and on beat 7 of an 8-beat burst. With no new request, valid drops on the next cycle.
- R9: A valid strobe in the cycle of the last beat starts the new burst's beat 0 on the next cycle, with no gap.
- R10: A strobe with the same direction during beat 3 of an 8-beat burst ends that burst and starts the new one on the next cycle.
- R11: A strobe at a beat other than 3 or the last beat is held, and it starts right after the next beat 3 that allows it. A later valid strobe replaces a held one.
- R12: A request whose direction differs from an 8-beat burst's direction does not interrupt that burst at beat 3. It starts after beat 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Burst request strobe |
| col_i | input | COL_W | Starting column address |
| len_i | input | 3 | Burst length code (3'd2 = 4 beats, 3'd3 = 8 beats) |
| order_i | input | 1 | 0 = sequential, 1 = interleaved |
| dir_i | input | 1 | Burst direction (0 = read, 1 = write) |
| beat_col_o | output | COL_W | Column address of the current beat |
| beat_valid_o | output | 1 | A beat is being presented |
| beat_last_o | output | 1 | The current beat is the final one |

## Verification
Directed bursts run every start offset under each ordering at both lengths. This separates sequential wrapping from linear counting, and it shows where bit 2 toggles versus where it is held. Back-to-back strobes, same-direction and opposite-direction strobes at beat 3, and strobes placed mid-quad separate seamless chaining, allowed interruption and deferral from each other. Invalid length codes, tried both while idle and while busy, show that nothing is started or held. A long seeded random run mixes all of these against a bench model.

// File: rtl/ddrbs_pkg.sv
package ddrbs_pkg;

  localparam int BEAT_W = 3;

  typedef enum logic [2:0] {
    LEN_4 = 3'd2,
    LEN_8 = 3'd3
  } len_code_e;

  // Only the two legal length codes start a burst.
  function automatic logic len_code_ok(input logic [2:0] code);
    return (code == LEN_4) || (code == LEN_8);
  endfunction

  // Index of the final beat for the selected length.
  function automatic logic [BEAT_W-1:0] final_beat(input logic bl8);
    return bl8 ? 3'd7 : 3'd3;
  endfunction

  // Low three column bits for one beat.
  // Bit 2 toggles only in the second half of an 8-beat burst.
  // Bits [1:0] either wrap-add or XOR the beat position.
  function automatic logic [2:0] beat_low3(input logic [2:0] start3,
                                           input logic [BEAT_W-1:0] beat,
                                           input logic bl8,
                                           input logic ilv);
    logic [1:0] low2;
    logic       b2;
    low2 = ilv ? (start3[1:0] ^ beat[1:0]) : (start3[1:0] + beat[1:0]);
    b2   = start3[2] ^ (bl8 & beat[2]);
    return {b2, low2};
  endfunction

endpackage

// File: rtl/ddrbs_req_hold.sv
module ddrbs_req_hold
  import ddrbs_pkg::*;
#(
  parameter int COL_W = 11
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [COL_W-1:0] col_i,
  input  logic [2:0]       len_i,
  input  logic             order_i,
  input  logic             dir_i,
  input  logic             take_i,
  input  logic             busy_i,
  output logic             req_v_o,
  output logic [COL_W-1:0] req_col_o,
  output logic             req_bl8_o,
  output logic             req_ilv_o,
  output logic             req_dir_o,
  output logic             pend_v_o
);

  logic             new_ok;
  logic             pend_q;
  logic [COL_W-1:0] pcol_q;
  logic             pbl8_q, pilv_q, pdir_q;

  assign new_ok = start_i & len_code_ok(len_i);

  // A fresh legal strobe wins over a parked request.
  assign req_v_o   = new_ok | pend_q;
  assign req_col_o = new_ok ? col_i            : pcol_q;
  assign req_bl8_o = new_ok ? (len_i == LEN_8) : pbl8_q;
  assign req_ilv_o = new_ok ? order_i          : pilv_q;
  assign req_dir_o = new_ok ? dir_i            : pdir_q;
  assign pend_v_o  = pend_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      pcol_q <= '0;
      pbl8_q <= 1'b0;
      pilv_q <= 1'b0;
      pdir_q <= 1'b0;
    end else if (take_i) begin
      pend_q <= 1'b0;
    end else if (new_ok) begin
      pend_q <= 1'b1;
      pcol_q <= col_i;
      pbl8_q <= (len_i == LEN_8);
      pilv_q <= order_i;
      pdir_q <= dir_i;
    end
  end

  // R11: a held request only exists while a burst runs
  p_pend_needs_busy_r11: assert property (@(posedge clk) disable iff (!rst_n)
    pend_q |-> busy_i);

  // R2: an illegal strobe with nothing held leaves the slot empty
  p_bad_len_dropped_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !len_code_ok(len_i) && !pend_q) |=> !pend_q);

endmodule

// File: rtl/ddrbs_beat_ctr.sv
module ddrbs_beat_ctr
  import ddrbs_pkg::*;
#(
  parameter int COL_W = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_v_i,
  input  logic [COL_W-1:0]  req_col_i,
  input  logic              req_bl8_i,
  input  logic              req_ilv_i,
  input  logic              req_dir_i,
  output logic              take_o,
  output logic              active_o,
  output logic [BEAT_W-1:0] beat_o,
  output logic [COL_W-1:0]  base_o,
  output logic              bl8_o,
  output logic              ilv_o,
  output logic              last_o
);

  logic              act_q;
  logic [BEAT_W-1:0] beat_q;
  logic [COL_W-1:0]  base_q;
  logic              bl8_q, ilv_q, dir_q;
  logic              quad_edge, at_end, same_dir;

  assign quad_edge = act_q & (beat_q[1:0] == 2'b11);
  assign at_end    = act_q & (beat_q == final_beat(bl8_q));
  assign same_dir  = (req_dir_i == dir_q);

  // Idle and final beat accept anything; mid-burst quad edge needs same direction.
  assign take_o = req_v_i & (~act_q | at_end | (quad_edge & same_dir));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      act_q  <= 1'b0;
      beat_q <= '0;
      base_q <= '0;
      bl8_q  <= 1'b0;
      ilv_q  <= 1'b0;
      dir_q  <= 1'b0;
    end else if (take_o) begin
      act_q  <= 1'b1;
      beat_q <= '0;
      base_q <= req_col_i;
      bl8_q  <= req_bl8_i;
      ilv_q  <= req_ilv_i;
      dir_q  <= req_dir_i;
    end else if (at_end) begin
      act_q  <= 1'b0;
      beat_q <= '0;
    end else if (act_q) begin
      beat_q <= beat_q + 1'b1;
    end
  end

  assign active_o = act_q;
  assign beat_o   = beat_q;
  assign base_o   = base_q;
  assign bl8_o    = bl8_q;
  assign ilv_o    = ilv_q;
  assign last_o   = at_end;

  // R10: a running burst is only replaced at a four-beat edge
  p_take_on_quad_edge_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (take_o && act_q) |-> (beat_q[1:0] == 2'b11));

  // R8: the final beat without a follow-on request leads to idle
  p_end_goes_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (last_o && !req_v_i) |=> !act_q);

  // R12: an opposite-direction request at beat 3 lets the burst continue to beat 4
  p_cross_dir_waits_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (act_q && bl8_q && beat_q == 3'd3 && req_v_i && req_dir_i != dir_q)
      |=> (act_q && beat_q == 3'd4));

endmodule

// File: rtl/ddrbs_addr_gen.sv
module ddrbs_addr_gen
  import ddrbs_pkg::*;
#(
  parameter int COL_W = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              active_i,
  input  logic              launch_i,
  input  logic [COL_W-1:0]  base_i,
  input  logic [BEAT_W-1:0] beat_i,
  input  logic              bl8_i,
  input  logic              ilv_i,
  output logic [COL_W-1:0]  col_o
);

  localparam int HI_W = COL_W - 3;

  logic [2:0] low3;

  assign low3  = beat_low3(base_i[2:0], beat_i, bl8_i, ilv_i);
  assign col_o = {base_i[COL_W-1:3], low3};

  // R7: upper bits hold for the whole burst
  p_upper_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (active_i && !launch_i) |=> $stable(col_o[COL_W-1:COL_W-HI_W]));

  // R4: bit 2 is fixed during a 4-beat burst
  p_bl4_bit2_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (active_i && !bl8_i && !launch_i) |=> $stable(col_o[2]));

endmodule

// File: rtl/ddr_burst_colseq.sv
module ddr_burst_colseq
  import ddrbs_pkg::*;
#(
  parameter int COL_W = 11
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [COL_W-1:0] col_i,
  input  logic [2:0]       len_i,
  input  logic             order_i,
  input  logic             dir_i,
  output logic [COL_W-1:0] beat_col_o,
  output logic             beat_valid_o,
  output logic             beat_last_o
);

  logic              req_v, req_bl8, req_ilv, req_dir, pend_v;
  logic [COL_W-1:0]  req_col;
  logic              take, active, bl8, ilv, last;
  logic [BEAT_W-1:0] beat;
  logic [COL_W-1:0]  base;

  ddrbs_req_hold #(.COL_W(COL_W)) u_hold (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_i   (start_i),
    .col_i     (col_i),
    .len_i     (len_i),
    .order_i   (order_i),
    .dir_i     (dir_i),
    .take_i    (take),
    .busy_i    (active),
    .req_v_o   (req_v),
    .req_col_o (req_col),
    .req_bl8_o (req_bl8),
    .req_ilv_o (req_ilv),
    .req_dir_o (req_dir),
    .pend_v_o  (pend_v)
  );

  ddrbs_beat_ctr #(.COL_W(COL_W)) u_ctr (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_v_i   (req_v),
    .req_col_i (req_col),
    .req_bl8_i (req_bl8),
    .req_ilv_i (req_ilv),
    .req_dir_i (req_dir),
    .take_o    (take),
    .active_o  (active),
    .beat_o    (beat),
    .base_o    (base),
    .bl8_o     (bl8),
    .ilv_o     (ilv),
    .last_o    (last)
  );

  ddrbs_addr_gen #(.COL_W(COL_W)) u_addr (
    .clk      (clk),
    .rst_n    (rst_n),
    .active_i (active),
    .launch_i (take),
    .base_i   (base),
    .beat_i   (beat),
    .bl8_i    (bl8),
    .ilv_i    (ilv),
    .col_o    (beat_col_o)
  );

  assign beat_valid_o = active;
  assign beat_last_o  = last;

  // R1: no last flag outside a burst
  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !beat_valid_o |-> !beat_last_o);

  // R11: a held request is never lost while it waits
  p_pend_stays_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_v && !take) |=> pend_v);

endmodule

// File: tb/test_ddr_burst_colseq.sv
module test_ddr_burst_colseq;
  localparam int COL_W = 11;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             start_i = 1'b0;
  logic [COL_W-1:0] col_i = '0;
  logic [2:0]       len_i = 3'd2;
  logic             order_i = 1'b0;
  logic             dir_i = 1'b0;
  logic [COL_W-1:0] beat_col_o;
  logic             beat_valid_o, beat_last_o;

  int n_chk = 0;
  int n_fail = 0;

  // reference model state
  bit m_act;
  int m_beat, m_col;
  bit m_bl8, m_ilv, m_dir;
  bit p_v;
  int p_col;
  bit p_bl8, p_ilv, p_dir;

  always #4 clk = ~clk;

  ddr_burst_colseq #(.COL_W(COL_W)) i_ddr_burst_colseq (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .col_i(col_i), .len_i(len_i),
    .order_i(order_i), .dir_i(dir_i), .beat_col_o(beat_col_o),
    .beat_valid_o(beat_valid_o), .beat_last_o(beat_last_o)
  );

  function automatic int ref_col(int col, int beat, bit bl8, bit ilv);
    int pos, half, s, hi, low, b2;
    pos  = beat % 4;
    half = beat / 4;
    s    = col % 8;
    hi   = col - s;
    if (ilv) low = (s % 4) ^ pos;
    else     low = ((s % 4) + pos) % 4;
    b2 = s / 4;
    if (bl8 && half == 1) b2 = 1 - b2;
    return hi + b2 * 4 + low;
  endfunction

  task automatic check(string tag);
    int exp_col;
    bit exp_last;
    exp_last = m_act && (m_beat == (m_bl8 ? 7 : 3));
    exp_col  = ref_col(m_col, m_beat, m_bl8, m_ilv);
    n_chk++;
    if (beat_valid_o !== m_act || beat_last_o !== exp_last ||
        (m_act && int'(beat_col_o) != exp_col)) begin
      n_fail++;
      $display("FAIL %s: valid/last/col = %0b/%0b/%0d expected %0b/%0b/%0d",
               tag, beat_valid_o, beat_last_o, beat_col_o,
               m_act, exp_last, m_act ? exp_col : int'(beat_col_o));
    end
  endtask

  task automatic model_step(bit s, int c, int l, bit o, bit d);
    bit nok, cv, cbl8, cilv, cdir, at_end, edge3, take;
    int ccol;
    nok = s && (l == 2 || l == 3);
    cv = nok || p_v;
    ccol = nok ? c : p_col;
    cbl8 = nok ? (l == 3) : p_bl8;
    cilv = nok ? o : p_ilv;
    cdir = nok ? d : p_dir;
    at_end = m_act && m_beat == (m_bl8 ? 7 : 3);
    edge3  = m_act && (m_beat % 4) == 3;
    take = cv && (!m_act || at_end || (edge3 && cdir == m_dir));
    if (take) begin
      m_act = 1; m_beat = 0; m_col = ccol; m_bl8 = cbl8; m_ilv = cilv; m_dir = cdir;
      p_v = 0;
    end else begin
      if (at_end) begin m_act = 0; m_beat = 0; end
      else if (m_act) m_beat++;
      if (nok) begin
        p_v = 1; p_col = c; p_bl8 = (l == 3); p_ilv = o; p_dir = d;
      end
    end
  endtask

  // one cycle: check present outputs, drive next inputs, advance model
  task automatic step(string tag, bit s, int c, int l, bit o, bit d);
    @(negedge clk);
    check(tag);
    start_i = s; col_i = COL_W'(c); len_i = 3'(l); order_i = o; dir_i = d;
    model_step(s, c, l, o, d);
  endtask

  task automatic idle(string tag, int n);
    for (int i = 0; i < n; i++) step(tag, 0, 0, 2, 0, 0);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    n_fail++; n_chk++;
    $display("FAIL watchdog: cycles exceeded, expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    int seed;
    seed = 7;
    void'($urandom(seed));
    repeat (3) @(negedge clk);
    check("R1 reset");
    rst_n = 1'b1;
    idle("R1 idle", 2);

    // R4 / R6 / R5 all start offsets, both orders, both lengths
    for (int l = 2; l <= 3; l++)
      for (int o = 0; o < 2; o++)
        for (int s = 0; s < 8; s++) begin
          step(o ? "R6 interleave" : (l == 3 ? "R5 seq8" : "R4 seq4"),
               1, 16 * 5 + s, l, o[0], 0);
          idle("R8 last beat", 9);
        end

    // R7 upper bits with a large column
    step("R7 upper", 1, 2047, 3, 0, 1);
    idle("R7 upper", 9);

    // R2 illegal length codes ignored while idle and while busy
    step("R2 bad len idle", 1, 3, 0, 0, 0);
    idle("R2 bad len idle", 3);
    step("R2 bad len busy", 1, 8, 3, 0, 0);
    step("R2 bad len busy", 1, 100, 7, 1, 0);
    step("R2 bad len busy", 1, 100, 1, 1, 0);
    idle("R2 bad len busy", 10);

    // R9 seamless chaining of 4-beat bursts (strobe on last beat)
    step("R9 seamless", 1, 32, 2, 0, 0);
    idle("R9 seamless", 3);
    step("R9 seamless", 1, 41, 2, 1, 0);
    idle("R9 seamless", 3);
    step("R9 seamless", 1, 54, 3, 0, 0);
    idle("R9 seamless", 10);

    // R10 same-direction interrupt at beat 3
    step("R10 interrupt", 1, 64, 3, 0, 1);
    idle("R10 interrupt", 3);
    step("R10 interrupt", 1, 77, 3, 1, 1);
    idle("R10 interrupt", 10);

    // R12 opposite direction waits for beat 7
    step("R12 cross dir", 1, 64, 3, 0, 1);
    idle("R12 cross dir", 3);
    step("R12 cross dir", 1, 90, 2, 0, 0);
    idle("R12 cross dir", 12);

    // R11 mid-quad strobe is deferred; a later strobe replaces it
    step("R11 defer", 1, 128, 3, 1, 0);
    step("R11 defer", 1, 200, 2, 0, 0);
    step("R11 defer", 1, 300, 2, 1, 0);
    idle("R11 defer", 12);

    // R3 constrained random mix
    for (int i = 0; i < 4000; i++) begin
      int r, l;
      r = $urandom_range(0, 99);
      l = ($urandom_range(0, 9) == 0) ? $urandom_range(0, 7) : $urandom_range(2, 3);
      step("R3 random", r < 30, $urandom_range(0, 2047), l,
           $urandom_range(0, 1), $urandom_range(0, 1));
    end
    idle("R1 idle end", 12);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule